// File: doc/BRIEF.md
# LPC Host Command Register Front End

This block is the software-facing side of a Low Pin Count host controller. Software uses a simple 32-bit register bus, with single-cycle reads and writes, to program a transfer. It sets a command word, a byte count and a target address, and it pushes outgoing data bytes. It then writes a launch bit. The block passes a descriptor to a separate bus cycle engine and waits for that engine to report the end of the transfer.

When the transfer ends, the block sets its idle status again and records whether the transfer succeeded. It also raises a sticky completion flag, which drives the interrupt output. Bytes that the engine receives are buffered, and software pops them one per register read. The two byte FIFOs sit between the register bus and the engine in both directions.

Register offsets on the byte-addressed bus:

- 0x00 is the launch register (bit 0).
- 0x04 is status: bit 0 is idle and bit 1 is finished.
- 0x08 holds the completion flag in bit 1.
- 0x10 is the byte count.
- 0x14 is the command.
- 0x20 is the address.
- 0x24 is the data push port.
- 0x28 is the data pop port.

Top module: `lpc_host_regs`

## Requirements
- R1: After reset, status (0x04) reads idle=1 and finished=0, the completion flag (0x08 bit 1) and `irq` are 0, and both FIFOs are empty.
- R2: Writing 1 to bit 0 of 0x00 while idle causes the following actions:
  - `eng_start` is high for exactly the one cycle after the write.
  - Idle drops to 0.
  - The engine fields follow the command at 0x14: bit 0 gives `eng_write` (1 = write), bits 2:1 give `eng_cycle` (0 = I/O, 1 = memory, 2 = firmware hub), and bit 3 gives `eng_fixed_addr` (1 = same address for every byte). `eng_addr` and `eng_count` carry 0x20 and 0x10.
- R3: A launch is ignored in each of these cases, with no `eng_start` and no status change:
  - the block is not idle;
  - bit 0 of the written value is 0;
  - the command is a write and the count is zero.
- R4: `eng_done` while busy returns idle to 1, sets finished to `eng_ok`, and sets the completion flag in the same edge.
- R5: Finished is cleared by every accepted launch and stays 0 when the engine ends with `eng_ok`=0.
- R6: Writing 1 to bit 1 of 0x08 clears the completion flag; writing 0 there leaves it; if a completion arrives in the same cycle as the clear, the flag ends set.
- R7: `irq` equals the completion flag level.
- R8: Each write to 0x24 pushes the low byte of the write data into a 16-deep write FIFO. The engine sees the bytes in push order at `eng_tx_byte` and takes them with `eng_tx_pop`. Pushes into a full FIFO are dropped.
- R9: Each read of 0x28 returns and removes the oldest byte pushed by `eng_rx_push`. A read while empty returns 0 and changes nothing. Engine pushes into a full 16-deep read FIFO are dropped.
- R10: The registers at 0x10, 0x14 (bits 3:0) and 0x20 read back the value last written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 8 | Byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the strobe cycle |
| eng_start | output | 1 | One-cycle launch to the engine |
| eng_write | output | 1 | Direction, 1 = write |
| eng_cycle | output | 2 | Cycle type |
| eng_fixed_addr | output | 1 | Hold address for every byte |
| eng_addr | output | 32 | Target address |
| eng_count | output | 8 | Byte count |
| eng_tx_byte | output | 8 | Head of write FIFO |
| eng_tx_empty | output | 1 | Write FIFO empty |
| eng_tx_pop | input | 1 | Engine takes a write byte |
| eng_rx_push | input | 1 | Engine delivers a read byte |
| eng_rx_byte | input | 8 | Read byte from engine |
| eng_done | input | 1 | Engine finished the transfer |
| eng_ok | input | 1 | Transfer succeeded, with `eng_done` |
| irq | output | 1 | Completion interrupt |

## Verification
The bench goes after these corner cases:

- A launch while busy. A design that accepts it would pulse `eng_start` twice and restart the engine mid-transfer.
- A zero-length write. A design that accepts it would hand the engine a transfer with nothing to send.
- FIFO overflow and underflow. A design that gets these wrong would corrupt the oldest byte on overflow, or return stale data and move its pointer on underflow.
- Clearing the flag in the same cycle that a completion arrives. A design that lets the clear win loses the interrupt.
- An abort. A design that leaves finished unchanged would report the earlier success.

Every command encoding is swept through readback and through the engine fields.

// File: rtl/lpc_host_regs.sv
module lpc_host_regs #(
  parameter int AW    = 8,
  parameter int LEN_W = 8,
  parameter int DEPTH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_wr,
  input  logic             bus_rd,
  input  logic [AW-1:0]    bus_addr,
  input  logic [31:0]      bus_wdata,
  output logic [31:0]      bus_rdata,
  output logic             eng_start,
  output logic             eng_write,
  output logic [1:0]       eng_cycle,
  output logic             eng_fixed_addr,
  output logic [31:0]      eng_addr,
  output logic [LEN_W-1:0] eng_count,
  output logic [7:0]       eng_tx_byte,
  output logic             eng_tx_empty,
  input  logic             eng_tx_pop,
  input  logic             eng_rx_push,
  input  logic [7:0]       eng_rx_byte,
  input  logic             eng_done,
  input  logic             eng_ok,
  output logic             irq
);
  localparam int PW = $clog2(DEPTH);
  localparam int CW = PW + 1;
  localparam logic [CW-1:0] FULL = CW'(DEPTH);

  localparam logic [AW-1:0] A_GO   = AW'(8'h00);
  localparam logic [AW-1:0] A_STAT = AW'(8'h04);
  localparam logic [AW-1:0] A_FLAG = AW'(8'h08);
  localparam logic [AW-1:0] A_LEN  = AW'(8'h10);
  localparam logic [AW-1:0] A_CMD  = AW'(8'h14);
  localparam logic [AW-1:0] A_ADR  = AW'(8'h20);
  localparam logic [AW-1:0] A_PUSH = AW'(8'h24);
  localparam logic [AW-1:0] A_POP  = AW'(8'h28);

  logic [3:0]       cmd;
  logic [LEN_W-1:0] len;
  logic [31:0]      adr;
  logic             idle, finished, done_flag;

  logic [7:0]    tx_mem [DEPTH];
  logic [7:0]    rx_mem [DEPTH];
  logic [PW-1:0] tx_wp, tx_rp, rx_wp, rx_rp;
  logic [CW-1:0] tx_cnt, rx_cnt;

  wire wr_go   = bus_wr && bus_addr == A_GO && bus_wdata[0];
  wire accept  = wr_go && idle && !(cmd[0] && len == '0);
  wire finish  = eng_done && !idle;
  wire tx_push = bus_wr && bus_addr == A_PUSH && tx_cnt != FULL;
  wire tx_pop  = eng_tx_pop && tx_cnt != '0;
  wire rx_push = eng_rx_push && rx_cnt != FULL;
  wire rx_pop  = bus_rd && bus_addr == A_POP && rx_cnt != '0;

  assign eng_write      = cmd[0];
  assign eng_cycle      = cmd[2:1];
  assign eng_fixed_addr = cmd[3];
  assign eng_addr       = adr;
  assign eng_count      = len;
  assign eng_tx_byte    = tx_mem[tx_rp];
  assign eng_tx_empty   = tx_cnt == '0;
  assign irq            = done_flag;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd <= '0; len <= '0; adr <= '0;
      idle <= 1'b1; finished <= 1'b0; done_flag <= 1'b0; eng_start <= 1'b0;
    end else begin
      eng_start <= accept;
      if (bus_wr && bus_addr == A_CMD) cmd <= bus_wdata[3:0];
      if (bus_wr && bus_addr == A_LEN) len <= bus_wdata[LEN_W-1:0];
      if (bus_wr && bus_addr == A_ADR) adr <= bus_wdata;
      if (accept) begin
        idle     <= 1'b0;
        finished <= 1'b0;
      end else if (finish) begin
        idle     <= 1'b1;
        finished <= eng_ok;
      end
      if (finish) done_flag <= 1'b1;
      else if (bus_wr && bus_addr == A_FLAG && bus_wdata[1]) done_flag <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (tx_push) tx_mem[tx_wp] <= bus_wdata[7:0];
    if (rx_push) rx_mem[rx_wp] <= eng_rx_byte;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_wp <= '0; tx_rp <= '0; tx_cnt <= '0;
      rx_wp <= '0; rx_rp <= '0; rx_cnt <= '0;
    end else begin
      if (tx_push) tx_wp <= PW'(tx_wp + 1'b1);
      if (tx_pop)  tx_rp <= PW'(tx_rp + 1'b1);
      tx_cnt <= tx_cnt + CW'(tx_push) - CW'(tx_pop);
      if (rx_push) rx_wp <= PW'(rx_wp + 1'b1);
      if (rx_pop)  rx_rp <= PW'(rx_rp + 1'b1);
      rx_cnt <= rx_cnt + CW'(rx_push) - CW'(rx_pop);
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_rd) begin
      case (bus_addr)
        A_STAT:  bus_rdata = {30'b0, finished, idle};
        A_FLAG:  bus_rdata = {30'b0, done_flag, 1'b0};
        A_LEN:   bus_rdata = 32'(len);
        A_CMD:   bus_rdata = {28'b0, cmd};
        A_ADR:   bus_rdata = adr;
        A_POP:   bus_rdata = (rx_cnt != '0) ? {24'b0, rx_mem[rx_rp]} : 32'b0;
        default: bus_rdata = '0;
      endcase
    end
  end
endmodule

module lpc_host_regs_chk #(
  parameter int DEPTH = 16,
  parameter int CW    = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          eng_start,
  input logic          eng_done,
  input logic          idle,
  input logic          finished,
  input logic          done_flag,
  input logic          irq,
  input logic [CW-1:0] tx_cnt,
  input logic [CW-1:0] rx_cnt
);
  p_start_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    eng_start |=> !eng_start);
  p_busy_on_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    eng_start |-> !idle);
  p_finished_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    eng_start |-> !finished);
  p_done_sets_flag_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_done && !idle) |=> (idle && done_flag));
  p_irq_rise_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(eng_done && !idle));
  p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
    32'(tx_cnt) <= DEPTH);
  p_no_overflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
    32'(rx_cnt) <= DEPTH);
endmodule

bind lpc_host_regs lpc_host_regs_chk #(.DEPTH(DEPTH), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .eng_start(eng_start), .eng_done(eng_done),
  .idle(idle), .finished(finished), .done_flag(done_flag), .irq(irq),
  .tx_cnt(tx_cnt), .rx_cnt(rx_cnt)
);

// File: tb/lpc_host_regs_test.sv
module lpc_host_regs_test;
  logic clk = 0, rst_n = 0;
  logic bus_wr = 0, bus_rd = 0;
  logic [7:0] bus_addr = 0;
  logic [31:0] bus_wdata = 0, bus_rdata;
  logic eng_start, eng_write, eng_fixed_addr, eng_tx_empty, irq;
  logic [1:0] eng_cycle;
  logic [31:0] eng_addr;
  logic [7:0] eng_count, eng_tx_byte;
  logic eng_tx_pop = 0, eng_rx_push = 0, eng_done = 0, eng_ok = 0;
  logic [7:0] eng_rx_byte = 0;
  int checks = 0, errors = 0;
  logic [31:0] v;

  always #5 clk = ~clk;

  lpc_host_regs uut (.*);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk); bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    @(negedge clk); bus_rd = 1; bus_addr = a; #1 d = bus_rdata;
    @(negedge clk); bus_rd = 0;
  endtask

  task automatic finish_eng(logic ok);
    @(negedge clk); eng_done = 1; eng_ok = ok;
    @(negedge clk); eng_done = 0; eng_ok = 0;
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    rd(8'h04, v); chk("R1 status", v, 32'h1);
    rd(8'h08, v); chk("R1 flag", v, 0);
    chk("R1 irq", irq, 0);
    chk("R1 tx empty", eng_tx_empty, 1);
    rd(8'h28, v); chk("R1 rx empty pop", v, 0);

    // R10 / R2 sweep of every command encoding
    for (int c = 0; c < 16; c++) begin
      wr(8'h14, 32'hFFFF_FFF0 | c);
      wr(8'h10, c + 1);
      wr(8'h20, 32'h1000_0000 + c * 32'h111);
      rd(8'h14, v); chk("R10 cmd readback", v, c);
      rd(8'h10, v); chk("R10 len readback", v, c + 1);
      rd(8'h20, v); chk("R10 addr readback", v, 32'h1000_0000 + c * 32'h111);
      chk("R2 write field", eng_write, c & 1);
      chk("R2 cycle field", eng_cycle, (c >> 1) & 3);
      chk("R2 fixed field", eng_fixed_addr, (c >> 3) & 1);
      chk("R2 count field", eng_count, c + 1);
    end

    // R2 launch
    wr(8'h14, 32'h1); wr(8'h10, 3);
    wr(8'h00, 1);
    chk("R2 start pulse", eng_start, 1);
    @(negedge clk); chk("R2 pulse one cycle", eng_start, 0);
    rd(8'h04, v); chk("R2 busy status", v, 0);
    // R3 launch while busy
    wr(8'h00, 1); chk("R3 busy launch ignored", eng_start, 0);
    @(negedge clk); chk("R3 no late pulse", eng_start, 0);
    // R4 success
    finish_eng(1);
    rd(8'h04, v); chk("R4 idle+finished", v, 32'h3);
    rd(8'h08, v); chk("R4 flag set", v, 32'h2);
    chk("R7 irq high", irq, 1);
    // R6 clear
    wr(8'h08, 32'h1); rd(8'h08, v); chk("R6 write 0 keeps", v, 32'h2);
    wr(8'h08, 32'h2); rd(8'h08, v); chk("R6 w1c", v, 0);
    chk("R7 irq low", irq, 0);

    // R3 bit0 zero, zero-length write
    wr(8'h00, 32'hFFFF_FFFE); chk("R3 bit0 zero", eng_start, 0);
    rd(8'h04, v); chk("R3 bit0 zero status", v, 32'h3);
    wr(8'h10, 0); wr(8'h00, 1); chk("R3 zero write", eng_start, 0);
    rd(8'h04, v); chk("R3 zero write status", v, 32'h3);
    // zero-length read is legal
    wr(8'h14, 0); wr(8'h00, 1); chk("R2 zero read accepted", eng_start, 1);
    rd(8'h04, v); chk("R5 finished cleared", v, 0);
    // R5 abort
    finish_eng(0);
    rd(8'h04, v); chk("R5 abort finished 0", v, 32'h1);
    rd(8'h08, v); chk("R5 abort flag", v, 32'h2);

    // R6 coincident clear and completion
    wr(8'h08, 2);
    wr(8'h00, 1);
    @(negedge clk); bus_wr = 1; bus_addr = 8'h08; bus_wdata = 2; eng_done = 1; eng_ok = 1;
    @(negedge clk); bus_wr = 0; eng_done = 0; eng_ok = 0;
    rd(8'h08, v); chk("R6 set wins", v, 32'h2);
    chk("R7 irq coincident", irq, 1);
    wr(8'h08, 2);

    // R8 write FIFO: 20 pushes, first 16 kept
    for (int i = 0; i < 20; i++) wr(8'h24, 32'hAB00 | ((i * 37 + 5) & 8'hFF));
    for (int i = 0; i < 16; i++) begin
      @(negedge clk);
      chk("R8 tx order", eng_tx_byte, (i * 37 + 5) & 8'hFF);
      chk("R8 tx not empty", eng_tx_empty, 0);
      eng_tx_pop = 1;
      @(negedge clk); eng_tx_pop = 0;
    end
    chk("R8 tx drained", eng_tx_empty, 1);
    @(negedge clk); eng_tx_pop = 1; @(negedge clk); eng_tx_pop = 0;
    chk("R8 empty pop harmless", eng_tx_empty, 1);

    // R9 read FIFO: 20 pushes, 16 kept, extra pop returns 0
    for (int i = 0; i < 20; i++) begin
      @(negedge clk); eng_rx_push = 1; eng_rx_byte = 8'((i * 53 + 9) & 8'hFF);
    end
    @(negedge clk); eng_rx_push = 0;
    for (int i = 0; i < 16; i++) begin
      rd(8'h28, v); chk("R9 rx order", v, (i * 53 + 9) & 8'hFF);
    end
    rd(8'h28, v); chk("R9 empty pop zero", v, 0);
    @(negedge clk); eng_rx_push = 1; eng_rx_byte = 8'h5A;
    @(negedge clk); eng_rx_push = 0;
    rd(8'h28, v); chk("R9 after underflow", v, 32'h5A);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule